// File: doc/BRIEF.md
# Page Attribute Bitmap Checker

This block screens every processor bus access against a flat table that keeps one 2-bit attribute per 1 MiB page of a 32-bit physical address space. The top twelve address bits select the page directly; no descriptors are searched and no address is translated. For each access the block reports, one clock later, whether the access may proceed, whether its data may be held in a cache, and a one-cycle fault flag when the access breaks the page's rule.

Software fills the table one entry per clock through a small write port carrying a page number and a code. Pages that hold memory shared with other bus masters, such as display or DMA buffers, are given the uncacheable read/write code so that the processor never keeps stale copies of them. After reset every page is open for reading and writing and may be cached, so the system boots without protection.

Top module: `page_attr_checker`

## Requirements
- R1: The page number of an access is address bits [31:20]; address bits [19:0] have no effect on the verdict.
- R2: Attribute codes are 2'b00 read-only cacheable, 2'b01 read/write uncacheable, 2'b10 read/write cacheable, 2'b11 undefined.
- R3: On a read-only page a read gives allow=1, cacheable=1, fault=0; a write gives fault=1, allow=0, cacheable=0.
- R4: On a read/write uncacheable page any access gives allow=1, cacheable=0, fault=0.
- R5: On a read/write cacheable page any access gives allow=1, cacheable=1, fault=0.
- R6: On an undefined page any access gives fault=1, allow=0, cacheable=0.
- R7: The verdict appears one clock after the request with rsp_valid=1; a clock with no request yields rsp_valid, rsp_allow, rsp_cacheable and rsp_fault all 0 on the following clock.
- R8: A table write stores one entry per clock; a lookup of the same page in the write's clock uses the old code, and a lookup in any later clock uses the new code.
- R9: During and after reset all outputs are 0 and every page holds code 2'b10.
- R10: A fault lasts exactly the one response clock of the offending request and never comes with allow or cacheable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present this clock |
| req_addr | input | 32 | Physical address of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 12 | Page number to program |
| cfg_code | input | 2 | Attribute code to store |
| rsp_valid | output | 1 | Verdict for the previous clock's request |
| rsp_allow | output | 1 | Access permitted |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_fault | output | 1 | One-clock fault pulse for a forbidden access |

## Verification
A corrupted table entry shows at the ports only when that page is next looked up, and then in the very next clock as a wrong allow, cacheable or fault value, so the bench sweeps accesses over programmed and untouched pages and reads back each page after rewriting it. A wrong write-versus-lookup ordering shows in the single clock after a same-page write and lookup, which the bench provokes on purpose. A stuck or stretched response register shows one clock after an idle cycle as a stray valid or fault.

// File: rtl/pab_pkg.sv
package pab_pkg;

   typedef enum logic [1:0] {
      PA_RO_C   = 2'b00,
      PA_RW_NC  = 2'b01,
      PA_RW_C   = 2'b10,
      PA_UNDEF  = 2'b11
   } pa_code_e;

   typedef struct packed {
      logic allow;
      logic cacheable;
      logic fault;
   } pa_verdict_s;

endpackage

// File: rtl/pab_table.sv
module pab_table
   import pab_pkg::*;
#(
   parameter int         IDX_W      = 12,
   parameter logic [1:0] RESET_CODE = PA_RW_C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [1:0]       wcode,
   input  logic [IDX_W-1:0] ridx,
   output logic [1:0]       rcode
);

   localparam int DEPTH = 1 << IDX_W;

   logic [1:0] ent [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent[i] <= RESET_CODE;
      end else if (we) begin
         ent[widx] <= wcode;
      end
   end

   // read sees the stored value, so a same-clock write is not yet visible
   assign rcode = ent[ridx];

   // R8
   entry_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ent[$past(widx)] == $past(wcode)));

endmodule

// File: rtl/pab_decode.sv
module pab_decode
   import pab_pkg::*;
(
   input  logic [1:0]  code,
   input  logic        is_write,
   output pa_verdict_s verdict
);

   always_comb begin
      verdict = '0;
      unique case (pa_code_e'(code))
         PA_RO_C: begin
            if (is_write) verdict.fault = 1'b1;
            else begin
               verdict.allow     = 1'b1;
               verdict.cacheable = 1'b1;
            end
         end
         PA_RW_NC: verdict.allow = 1'b1;
         PA_RW_C: begin
            verdict.allow     = 1'b1;
            verdict.cacheable = 1'b1;
         end
         PA_UNDEF: verdict.fault = 1'b1;
         default: verdict = '0;
      endcase
   end

endmodule

// File: rtl/page_attr_checker.sv
module page_attr_checker
   import pab_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 20
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic                          req_write,
   input  logic                          cfg_we,
   input  logic [ADDR_W-PAGE_SHIFT-1:0]  cfg_idx,
   input  logic [1:0]                    cfg_code,
   output logic                          rsp_valid,
   output logic                          rsp_allow,
   output logic                          rsp_cacheable,
   output logic                          rsp_fault
);

   localparam int IDX_W = ADDR_W - PAGE_SHIFT;

   generate
      if (PAGE_SHIFT < 1 || PAGE_SHIFT >= ADDR_W) begin : g_bad_shift
         $error("page_attr_checker: PAGE_SHIFT must lie in 1..ADDR_W-1");
      end
      if (IDX_W > 14) begin : g_bad_depth
         $error("page_attr_checker: page table too deep for flop storage");
      end
   endgenerate

   logic [IDX_W-1:0] page_idx;
   logic [1:0]       tbl_code;
   pa_verdict_s      verdict;

   assign page_idx = req_addr[ADDR_W-1:PAGE_SHIFT];

   pab_table #(
      .IDX_W      (IDX_W),
      .RESET_CODE (PA_RW_C)
   ) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .widx  (cfg_idx),
      .wcode (cfg_code),
      .ridx  (page_idx),
      .rcode (tbl_code)
   );

   pab_decode u_decode (
      .code     (tbl_code),
      .is_write (req_write),
      .verdict  (verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_allow     <= 1'b0;
         rsp_cacheable <= 1'b0;
         rsp_fault     <= 1'b0;
      end else begin
         rsp_valid     <= req_valid;
         rsp_allow     <= req_valid & verdict.allow;
         rsp_cacheable <= req_valid & verdict.cacheable;
         rsp_fault     <= req_valid & verdict.fault;
      end
   end

   // R7
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_allow && !rsp_cacheable && !rsp_fault);

   // R10
   fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_valid && !rsp_allow && !rsp_cacheable);

   // R3
   ro_write_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && tbl_code == PA_RO_C) |=> rsp_fault);

   // R6
   undef_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tbl_code == PA_UNDEF) |=> rsp_fault);

   // R4
   nocache_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tbl_code == PA_RW_NC) |=> rsp_allow && !rsp_cacheable);

endmodule

// File: tb/page_attr_checker_tb.sv
module page_attr_checker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_idx = '0;
   logic [1:0]  cfg_code = '0;
   logic        rsp_valid, rsp_allow, rsp_cacheable, rsp_fault;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 0;

   logic [1:0] model [4096];
   logic       e_valid, e_allow, e_cache, e_fault;
   string      e_tag = "R9";
   string      cur_tag = "";

   always #5 clk = ~clk;

   page_attr_checker u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
      .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
      .rsp_cacheable(rsp_cacheable), .rsp_fault(rsp_fault)
   );

   // reference model: lookup with pre-write contents, then apply write
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4096; i++) model[i] = 2'b10;   // R9
         {e_valid, e_allow, e_cache, e_fault} = 4'b0000;
         e_tag = "R9";
      end else begin
         logic [1:0] c;
         c = model[req_addr[31:20]];
         e_valid = req_valid; e_allow = 0; e_cache = 0; e_fault = 0;
         if (!req_valid) e_tag = "R7";
         else begin
            case (c)
               2'b00: begin e_tag = "R3";
                  if (req_write) e_fault = 1; else begin e_allow = 1; e_cache = 1; end end
               2'b01: begin e_tag = "R4"; e_allow = 1; end
               2'b10: begin e_tag = "R5"; e_allow = 1; e_cache = 1; end
               default: begin e_tag = "R6"; e_fault = 1; end
            endcase
         end
         if (cur_tag != "") e_tag = cur_tag;
         if (cfg_we) model[cfg_idx] = cfg_code;
      end
   end

   // compare on every falling edge once out of reset
   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if ({rsp_valid, rsp_allow, rsp_cacheable, rsp_fault} !==
             {e_valid, e_allow, e_cache, e_fault}) begin
            bad++;
            $display("FAIL %s: got v/a/c/f=%b%b%b%b expected %b%b%b%b", e_tag,
                     rsp_valid, rsp_allow, rsp_cacheable, rsp_fault,
                     e_valid, e_allow, e_cache, e_fault);
         end
      end
   end

   task automatic acc(input logic [31:0] a, input logic wr, input string tag);
      @(negedge clk);
      cfg_we = 0; req_valid = 1; req_addr = a; req_write = wr; cur_tag = tag;
      @(negedge clk);
      req_valid = 0; cur_tag = "";
   endtask

   task automatic prog(input logic [11:0] idx, input logic [1:0] code);
      @(negedge clk);
      req_valid = 0; cfg_we = 1; cfg_idx = idx; cfg_code = code;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         bad++; total++;
         $display("FAIL watchdog: got cycles=%0d expected <=100000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: outputs quiet while in reset
      total++;
      if ({rsp_valid, rsp_allow, rsp_cacheable, rsp_fault} !== 4'b0000) begin
         bad++;
         $display("FAIL R9: got %b%b%b%b expected 0000",
                  rsp_valid, rsp_allow, rsp_cacheable, rsp_fault);
      end
      rst_n = 1;
      // R9: every page open and cacheable after reset
      acc(32'h0000_0000, 1'b1, "R9");
      acc(32'hFFFF_FFFF, 1'b0, "R9");
      acc(32'h7AB1_2345, 1'b1, "R9");
      // R2/R3: read-only page 5
      prog(12'd5, 2'b00);
      acc(32'h0050_0000, 1'b0, "R3");
      acc(32'h0050_0004, 1'b1, "R3");
      // R1: low address bits do not change the page
      acc(32'h005F_FFFF, 1'b1, "R1");
      acc(32'h0040_0000, 1'b1, "R1");
      acc(32'h0060_0000, 1'b1, "R1");
      // R4 / R6
      prog(12'd6, 2'b01);
      prog(12'd7, 2'b11);
      acc(32'h0068_0000, 1'b1, "R4");
      acc(32'h0070_0010, 1'b0, "R6");
      acc(32'h0071_0000, 1'b1, "R6");
      // R10: fault pulse ends after one clock (idle follows)
      acc(32'h0050_0000, 1'b1, "R10");
      @(negedge clk);
      // R8: same-clock write and lookup of page 8 sees old code
      @(negedge clk);
      cfg_we = 1; cfg_idx = 12'd8; cfg_code = 2'b11;
      req_valid = 1; req_addr = 32'h0080_0000; req_write = 0; cur_tag = "R8";
      @(negedge clk);
      cfg_we = 0; req_valid = 0; cur_tag = "";
      acc(32'h0080_0000, 1'b0, "R8");
      // back-to-back writes then read-back
      prog(12'd8, 2'b01);
      prog(12'd8, 2'b00);
      acc(32'h008A_BCDE, 1'b1, "R8");
      // R2: random mix of writes and accesses
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         cfg_we    = ($urandom % 3) == 0;
         cfg_idx   = 12'($urandom % 16);
         cfg_code  = 2'($urandom);
         req_valid = ($urandom % 4) != 0;
         req_addr  = {4'h0, 8'($urandom % 16), 20'($urandom)};
         req_addr[31:20] = 12'($urandom % 16);
         req_write = 1'($urandom);
      end
      @(negedge clk);
      cfg_we = 0; req_valid = 0;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule